// File: doc/BRIEF.md
# Shift and Rotate Unit

A single-cycle combinational unit for the integer datapath of a microcoded core. It carries out every operation that moves the bits of one operand by a count. There are three shifts (left, logical right, arithmetic right), two plain rotates (left, right) and two rotates that pass through the carry flag (left, right). The count comes either from a register operand or from a short immediate. The operand size can be 8, 16, 32 or 64 bits. The unit also takes the current carry flag as an input.

Along with the result, the unit returns new values for the carry flag, its shadow copy (the extended carry used by microcode) and the overflow flag. Each of the three flags has its own write enable. The surrounding pipeline applies the flag values only where the enable is high. The rule for each flag depends on the operation. A masked count of zero leaves every flag untouched.

The block has no clock, no state and no state machine. Every output is a pure function of the current inputs.

Top module: `shrot_unit`

## Requirements
- R1: The count source is `amt_imm` when `use_imm`=1 and `amt_reg` otherwise. The count is truncated to its low 6 bits when `size_sel`=3 (64-bit). For any other size it is truncated to its low 5 bits.
- R2: When the truncated count is 0, or when `op_sel`=7 (no operation), `cf_we`, `ecf_we` and `of_we` are all 0. `result` then equals the size-masked operand.
- R3: Left shift (`op_sel`=0): zeros fill from the bottom. CF is the last bit shifted out, or 0 once the count exceeds the size. OF is CF XOR the result MSB.
- R4: Logical right shift (`op_sel`=1): zeros fill from the top. CF is the last bit shifted out. OF is the MSB of the original operand. A count at or above the size gives 0.
- R5: Arithmetic right shift (`op_sel`=2): copies of the sign bit fill from the top. CF is the last bit shifted out, or the sign bit once the count exceeds the size. OF is 0.
- R6: Rotate left (`op_sel`=3) uses the count modulo the size. CF is the result LSB. OF is the result MSB XOR the result LSB.
- R7: Rotate right (`op_sel`=4) uses the count modulo the size. CF is the result MSB. OF is the XOR of the two top bits of the original operand.
- R8: Rotate left through carry (`op_sel`=5) rotates a (size+1)-bit ring made of the operand with the carry above it. It uses the count modulo size+1. CF is the bit that ends in the carry position. OF is the incoming carry XOR the result MSB.
- R9: Rotate right through carry (`op_sel`=6) uses the same ring and the same modulo. CF is the bit that ends in the carry position. OF is the incoming carry XOR the MSB of the original operand.
- R10: `size_sel` codes 0, 1, 2 and 3 select 8, 16, 32 and 64 bits. Operand bits above the size are ignored, and `result` bits above the size are 0.
- R11: When the count is nonzero, `cf_we` and `of_we` are 1 for op codes 0 to 6. `ecf_we` is 1 only for op codes 0, 1, 3 and 4, and then `ecf_out` equals `cf_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (0 to 6 as in R3 to R9, 7 = no operation) |
| size_sel | input | 2 | Operand size code (R10) |
| src_a | input | 64 | Operand to be shifted or rotated |
| use_imm | input | 1 | Select the immediate count instead of the register count |
| amt_reg | input | 64 | Count from a register operand |
| amt_imm | input | 8 | Count from the immediate field |
| carry_in | input | 1 | Current carry flag |
| result | output | 64 | Shifted or rotated value, zero above the operand size |
| cf_out | output | 1 | New carry flag value |
| cf_we | output | 1 | Carry flag write enable |
| ecf_out | output | 1 | New extended carry flag value |
| ecf_we | output | 1 | Extended carry flag write enable |
| of_out | output | 1 | New overflow flag value |
| of_we | output | 1 | Overflow flag write enable |

## Verification
Every output is combinational, so each result and flag is valid in the same cycle as the inputs that produce it, with no register in between. The bench applies each vector at the falling clock edge and samples the outputs 1 ns later, well before the next rising edge, so no result depends on the order of events at a clock edge. Expected values come from a model that moves the operand one bit position at a time, once per count step. This is structurally different from the barrel logic in the design, and it covers counts past the operand size as well as the modulo wrap of both kinds of rotate.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_SHL = 3'd0,
        OP_SHR = 3'd1,
        OP_SAR = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_RCL = 3'd5,
        OP_RCR = 3'd6,
        OP_NOP = 3'd7
    } shrot_op_e;

    typedef struct packed {
        logic cf;
        logic cf_we;
        logic ecf;
        logic ecf_we;
        logic of;
        logic of_we;
    } shrot_flags_t;

endpackage

// File: rtl/shrot_count.sv
module shrot_count
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    parameter int SIZE_W = 2,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic [SIZE_W-1:0] size_sel,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [IMM_W-1:0]  amt_imm,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W:0]    rot_cnt,
    output logic [CNT_W:0]    ring_cnt,
    output logic [CNT_W:0]    width,
    output logic [DATA_W-1:0] mask
);
    localparam int SIZE_N = 1 << SIZE_W;
    localparam logic [SIZE_W-1:0] SIZE_TOP = SIZE_W'(SIZE_N - 1);

    logic [CNT_W-1:0]  raw_lo;
    logic [CNT_W:0]    rot_c  [SIZE_N];
    logic [CNT_W:0]    ring_c [SIZE_N];
    logic [CNT_W:0]    wid_c  [SIZE_N];
    logic [DATA_W-1:0] msk_c  [SIZE_N];
    logic              unused_hi;

    assign unused_hi = ^{amt_reg[DATA_W-1:CNT_W], amt_imm[IMM_W-1:CNT_W]};

    always_comb begin
        raw_lo = use_imm ? amt_imm[CNT_W-1:0] : amt_reg[CNT_W-1:0];
        cnt    = raw_lo;
        if (size_sel != SIZE_TOP) begin
            cnt[CNT_W-1] = 1'b0;
        end
    end

    for (genvar k = 0; k < SIZE_N; k++) begin : g_size
        localparam int WK = DATA_W >> (SIZE_N - 1 - k);
        assign rot_c[k]  = (CNT_W+1)'(32'(cnt) % WK);
        assign ring_c[k] = (CNT_W+1)'(32'(cnt) % (WK + 1));
        assign wid_c[k]  = (CNT_W+1)'(WK);
        assign msk_c[k]  = {DATA_W{1'b1}} >> (DATA_W - WK);
    end

    assign rot_cnt  = rot_c[size_sel];
    assign ring_cnt = ring_c[size_sel];
    assign width    = wid_c[size_sel];
    assign mask     = msk_c[size_sel];

    always_comb begin
        if (size_sel != SIZE_TOP) begin
            AST_NARROW_COUNT: assert (raw_lo[CNT_W-2:0] == cnt[CNT_W-2:0] && !cnt[CNT_W-1]) else $error("count truncation"); // R1
        end
        AST_ROT_BELOW_SIZE: assert (rot_cnt < width && ring_cnt <= width) else $error("modulo count out of range"); // R6
    end

endmodule

// File: rtl/shrot_shift.sv
module shrot_shift
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  shrot_op_e         op,
    input  logic [DATA_W-1:0] a,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W:0]    width,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] res,
    output logic              last_out
);
    logic [CNT_W:0]    cnt_x;
    logic              in_range;
    logic              reach;
    logic              sgn;
    logic [DATA_W-1:0] msb_mask;
    logic [DATA_W-1:0] sx;
    logic [DATA_W-1:0] shl_v, shr_v, sar_v;
    logic [DATA_W-1:0] shl_tap, shr_tap, sar_tap;

    always_comb begin
        cnt_x    = {1'b0, cnt};
        in_range = cnt_x < width;
        reach    = cnt_x <= width;
        msb_mask = mask ^ (mask >> 1);
        sgn      = |(a & msb_mask);
        sx       = a | (sgn ? ~mask : '0);

        shl_v   = in_range ? ((a << cnt) & mask) : '0;
        shr_v   = in_range ? (a >> cnt) : '0;
        sar_v   = DATA_W'($signed(sx) >>> cnt) & mask;

        shl_tap = a >> (width - cnt_x);
        shr_tap = a >> (cnt - 1'b1);
        sar_tap = sx >> (cnt - 1'b1);

        res      = a;
        last_out = 1'b0;
        unique case (op)
            OP_SHL: begin
                res      = shl_v;
                last_out = reach & shl_tap[0];
            end
            OP_SHR: begin
                res      = shr_v;
                last_out = shr_tap[0];
            end
            OP_SAR: begin
                res      = sar_v;
                last_out = sar_tap[0];
            end
            default: begin
                res      = a;
                last_out = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (op == OP_SAR) begin
            AST_SAR_KEEPS_SIGN: assert ((|(res & msb_mask)) == sgn) else $error("sign lost"); // R5
        end
        if (op == OP_SHR && cnt != '0) begin
            AST_SHR_TOP_CLEAR: assert ((res & msb_mask) == '0) else $error("logical shift filled a one"); // R4
        end
    end

endmodule

// File: rtl/shrot_rotate.sv
module shrot_rotate
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  shrot_op_e         op,
    input  logic [DATA_W-1:0] a,
    input  logic              carry_in,
    input  logic [CNT_W:0]    rot_cnt,
    input  logic [CNT_W:0]    ring_cnt,
    input  logic [CNT_W:0]    width,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] res,
    output logic              ring_out
);
    localparam int RING_W = DATA_W + 1;

    logic [RING_W-1:0] top_bit;
    logic [RING_W-1:0] ring;
    logic [RING_W-1:0] ring_mask;
    logic [RING_W-1:0] rcl_ring, rcr_ring, sel_ring;
    logic [CNT_W:0]    ring_len;
    logic [DATA_W-1:0] rol_v, ror_v;

    always_comb begin
        top_bit   = RING_W'(1) << width;
        ring      = {1'b0, a} | (carry_in ? top_bit : '0);
        ring_mask = {1'b0, mask} | top_bit;
        ring_len  = width + 1'b1;

        rol_v = ((a << rot_cnt) | (a >> (width - rot_cnt))) & mask;
        ror_v = ((a >> rot_cnt) | (a << (width - rot_cnt))) & mask;

        rcl_ring = ((ring << ring_cnt) | (ring >> (ring_len - ring_cnt))) & ring_mask;
        rcr_ring = ((ring >> ring_cnt) | (ring << (ring_len - ring_cnt))) & ring_mask;

        sel_ring = ring;
        res      = a;
        unique case (op)
            OP_ROL:  res = rol_v;
            OP_ROR:  res = ror_v;
            OP_RCL: begin
                sel_ring = rcl_ring;
                res      = rcl_ring[DATA_W-1:0] & mask;
            end
            OP_RCR: begin
                sel_ring = rcr_ring;
                res      = rcr_ring[DATA_W-1:0] & mask;
            end
            default: res = a;
        endcase
        ring_out = |(sel_ring & top_bit);
    end

    always_comb begin
        if (op == OP_ROL || op == OP_ROR) begin
            AST_ROT_KEEPS_ONES: assert ($countones(res) == $countones(a)) else $error("rotate lost bits"); // R6
        end
        if (op == OP_RCL || op == OP_RCR) begin
            AST_RING_KEEPS_ONES: assert ($countones(sel_ring) == $countones(ring)) else $error("ring lost bits"); // R8
        end
    end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  shrot_op_e         op,
    input  logic              cnt_nz,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] mask,
    input  logic              carry_in,
    input  logic              shift_out,
    input  logic              ring_out,
    output shrot_flags_t      flags
);
    logic [DATA_W-1:0] msb_mask;
    logic msb_r, msb_a, msb2_a, lsb_r;
    logic cf_v, of_v, ecf_ok, any_op;

    always_comb begin
        msb_mask = mask ^ (mask >> 1);
        msb_r    = |(res & msb_mask);
        msb_a    = |(a & msb_mask);
        msb2_a   = |(a & (msb_mask >> 1));
        lsb_r    = res[0];

        cf_v   = 1'b0;
        of_v   = 1'b0;
        ecf_ok = 1'b0;
        any_op = 1'b1;
        unique case (op)
            OP_SHL: begin cf_v = shift_out; of_v = shift_out ^ msb_r; ecf_ok = 1'b1; end
            OP_SHR: begin cf_v = shift_out; of_v = msb_a;             ecf_ok = 1'b1; end
            OP_SAR: begin cf_v = shift_out; of_v = 1'b0;                             end
            OP_ROL: begin cf_v = lsb_r;     of_v = msb_r ^ lsb_r;     ecf_ok = 1'b1; end
            OP_ROR: begin cf_v = msb_r;     of_v = msb_a ^ msb2_a;    ecf_ok = 1'b1; end
            OP_RCL: begin cf_v = ring_out;  of_v = carry_in ^ msb_r;                 end
            OP_RCR: begin cf_v = ring_out;  of_v = carry_in ^ msb_a;                 end
            default: any_op = 1'b0;
        endcase

        flags.cf_we  = cnt_nz & any_op;
        flags.of_we  = cnt_nz & any_op;
        flags.ecf_we = cnt_nz & ecf_ok;
        flags.cf     = flags.cf_we & cf_v;
        flags.of     = flags.of_we & of_v;
        flags.ecf    = flags.ecf_we & cf_v;
    end

    always_comb begin
        if (!cnt_nz) begin
            AST_ZERO_COUNT_QUIET: assert (!flags.cf_we && !flags.of_we && !flags.ecf_we) else $error("flag write on zero count"); // R2
        end
        if (flags.ecf_we) begin
            AST_ECF_OPS_ONLY: assert (flags.cf_we && (op == OP_SHL || op == OP_SHR || op == OP_ROL || op == OP_ROR)) else $error("ecf write on wrong op"); // R11
        end
        if (op == OP_SAR) begin
            AST_SAR_OF_CLEAR: assert (!flags.of) else $error("sar set OF"); // R5
        end
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    parameter int SIZE_W = 2
) (
    input  logic [2:0]        op_sel,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [IMM_W-1:0]  amt_imm,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              cf_out,
    output logic              cf_we,
    output logic              ecf_out,
    output logic              ecf_we,
    output logic              of_out,
    output logic              of_we
);
    localparam int CNT_W = $clog2(DATA_W);

    shrot_op_e         op;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W:0]    rot_cnt, ring_cnt, width;
    logic [DATA_W-1:0] mask, a_m, sh_res, ro_res;
    logic              sh_out, ring_out;
    shrot_flags_t      flags;

    assign op  = shrot_op_e'(op_sel);
    assign a_m = src_a & mask;

    shrot_count #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_count (
        .size_sel (size_sel),
        .use_imm  (use_imm),
        .amt_reg  (amt_reg),
        .amt_imm  (amt_imm),
        .cnt      (cnt),
        .rot_cnt  (rot_cnt),
        .ring_cnt (ring_cnt),
        .width    (width),
        .mask     (mask)
    );

    shrot_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .op       (op),
        .a        (a_m),
        .cnt      (cnt),
        .width    (width),
        .mask     (mask),
        .res      (sh_res),
        .last_out (sh_out)
    );

    shrot_rotate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rotate (
        .op       (op),
        .a        (a_m),
        .carry_in (carry_in),
        .rot_cnt  (rot_cnt),
        .ring_cnt (ring_cnt),
        .width    (width),
        .mask     (mask),
        .res      (ro_res),
        .ring_out (ring_out)
    );

    shrot_flags #(.DATA_W(DATA_W)) u_flags (
        .op        (op),
        .cnt_nz    (cnt != '0),
        .a         (a_m),
        .res       (result),
        .mask      (mask),
        .carry_in  (carry_in),
        .shift_out (sh_out),
        .ring_out  (ring_out),
        .flags     (flags)
    );

    always_comb begin
        unique case (op)
            OP_SHL, OP_SHR, OP_SAR:         result = sh_res;
            OP_ROL, OP_ROR, OP_RCL, OP_RCR: result = ro_res;
            default:                        result = a_m;
        endcase
    end

    assign cf_out  = flags.cf;
    assign cf_we   = flags.cf_we;
    assign ecf_out = flags.ecf;
    assign ecf_we  = flags.ecf_we;
    assign of_out  = flags.of;
    assign of_we   = flags.of_we;

    always_comb begin
        AST_RESULT_FITS_SIZE: assert ((result & ~mask) == '0) else $error("result above size"); // R10
        if (cnt == '0) begin
            AST_ZERO_COUNT_PASS: assert (result == a_m) else $error("zero count changed value"); // R2
        end
    end

endmodule

// File: tb/tb_shrot_unit.sv
`timescale 1ns/1ps
module tb_shrot_unit;

    logic        clk = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic [63:0] src_a = '0;
    logic        use_imm = 1'b0;
    logic [63:0] amt_reg = '0;
    logic [7:0]  amt_imm = '0;
    logic        carry_in = 1'b0;
    logic [63:0] result;
    logic        cf_out, cf_we, ecf_out, ecf_we, of_out, of_we;

    int vectors = 0;
    int fails   = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    shrot_unit dut (
        .op_sel(op_sel), .size_sel(size_sel), .src_a(src_a), .use_imm(use_imm),
        .amt_reg(amt_reg), .amt_imm(amt_imm), .carry_in(carry_in),
        .result(result), .cf_out(cf_out), .cf_we(cf_we), .ecf_out(ecf_out),
        .ecf_we(ecf_we), .of_out(of_out), .of_we(of_we)
    );

    function automatic logic [63:0] next_rand(logic [63:0] s);
        logic [63:0] x = s;
        x ^= x << 13;
        x ^= x >> 7;
        x ^= x << 17;
        return x;
    endfunction

    // Bit-serial reference: one position per step.
    task automatic model(input logic [2:0] op, input logic [1:0] sz, input logic [63:0] a,
                         input logic [63:0] raw, input logic cin,
                         output logic [63:0] e_res, output logic e_cf, output logic e_of,
                         output logic e_we, output logic e_ecf_we);
        int w = 8 << sz;
        logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 1);
        int c = (sz == 2'd3) ? int'(raw[5:0]) : int'(raw[4:0]);
        logic [63:0] v = a & msk;
        logic [63:0] a0 = a & msk;
        logic cf = cin;
        logic s = a0[w-1];
        logic b;
        for (int i = 0; i < c; i++) begin
            case (op)
                3'd0: begin cf = v[w-1]; v = (v << 1) & msk; end
                3'd1: begin cf = v[0]; v = v >> 1; end
                3'd2: begin cf = v[0]; v = (v >> 1) | (64'(s) << (w-1)); end
                3'd3: begin b = v[w-1]; v = ((v << 1) | 64'(b)) & msk; end
                3'd4: begin b = v[0]; v = (v >> 1) | (64'(b) << (w-1)); end
                3'd5: begin b = v[w-1]; v = ((v << 1) | 64'(cf)) & msk; cf = b; end
                3'd6: begin b = v[0]; v = (v >> 1) | (64'(cf) << (w-1)); cf = b; end
                default: ;
            endcase
        end
        e_res = v;
        case (op)
            3'd0: e_of = cf ^ v[w-1];
            3'd1: e_of = a0[w-1];
            3'd2: e_of = 1'b0;
            3'd3: begin cf = v[0]; e_of = v[w-1] ^ v[0]; end
            3'd4: begin cf = v[w-1]; e_of = a0[w-1] ^ a0[w-2]; end
            3'd5: e_of = cin ^ v[w-1];
            3'd6: e_of = cin ^ a0[w-1];
            default: e_of = 1'b0;
        endcase
        e_cf     = cf;
        e_we     = (c != 0) && (op != 3'd7);
        e_ecf_we = e_we && (op == 3'd0 || op == 3'd1 || op == 3'd3 || op == 3'd4);
    endtask

    task automatic apply(input string tag, input logic [2:0] op, input logic [1:0] sz,
                         input logic [63:0] a, input logic [63:0] amt, input logic imm,
                         input logic cin);
        logic [63:0] e_res, raw;
        logic e_cf, e_of, e_we, e_ecf_we, bad;
        @(negedge clk);
        op_sel = op; size_sel = sz; src_a = a; use_imm = imm; carry_in = cin;
        lfsr = next_rand(lfsr);
        if (imm) begin amt_imm = amt[7:0]; amt_reg = lfsr; raw = {56'd0, amt[7:0]}; end
        else     begin amt_reg = amt; amt_imm = lfsr[7:0]; raw = amt; end
        model(op, sz, a, raw, cin, e_res, e_cf, e_of, e_we, e_ecf_we);
        #1;
        vectors++;
        bad = (result !== e_res) || (cf_we !== e_we) || (of_we !== e_we) || (ecf_we !== e_ecf_we);
        if (e_we && (cf_out !== e_cf || of_out !== e_of)) bad = 1'b1;
        if (e_ecf_we && ecf_out !== e_cf) bad = 1'b1;
        if (bad) begin
            fails++;
            $display("FAIL %s op=%0d sz=%0d a=%h cnt=%h cin=%b: got res=%h cf=%b/%b of=%b/%b ecf=%b/%b exp res=%h cf=%b/%b of=%b/%b ecf=%b/%b",
                     tag, op, sz, a, raw, cin, result, cf_out, cf_we, of_out, of_we, ecf_out, ecf_we,
                     e_res, e_cf, e_we, e_of, e_we, e_cf, e_ecf_we);
        end
    endtask

    function automatic string op_tag(int op);
        case (op)
            0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
            4: return "R7"; 5: return "R8"; default: return "R9";
        endcase
    endfunction

    task automatic test_idle();           // R2 state with all inputs quiet
        apply("R2", 3'd0, 2'd0, 64'h0, 64'd0, 1'b0, 1'b0);
        apply("R2", 3'd7, 2'd3, 64'hDEAD_BEEF_0123_4567, 64'd5, 1'b0, 1'b1);
    endtask

    task automatic test_zero_count();     // R2
        for (int op = 0; op < 7; op++)
            apply("R2", 3'(op), 2'd2, 64'hFFFF_FFFF_8000_0001, 64'h40, 1'b0, 1'b1);
        apply("R2", 3'd5, 2'd0, 64'h81, 64'h20, 1'b1, 1'b1);
    endtask

    task automatic test_count_trunc();    // R1
        apply("R1", 3'd1, 2'd0, 64'hF0, 64'h21, 1'b0, 1'b0);
        apply("R1", 3'd0, 2'd3, 64'h1, 64'h41, 1'b1, 1'b0);
        apply("R1", 3'd0, 2'd3, 64'h1, 64'h3F, 1'b0, 1'b0);
        apply("R1", 3'd4, 2'd1, 64'h1234, 64'hFFFF_FFFF_FFFF_FFE3, 1'b0, 1'b0);
    endtask

    task automatic test_shifts();         // R3 R4 R5
        apply("R3", 3'd0, 2'd0, 64'h81, 64'd1, 1'b1, 1'b0);
        apply("R3", 3'd0, 2'd1, 64'h8001, 64'd16, 1'b1, 1'b0);
        apply("R3", 3'd0, 2'd0, 64'hFF, 64'd20, 1'b1, 1'b1);
        apply("R4", 3'd1, 2'd2, 64'h8000_0003, 64'd2, 1'b0, 1'b0);
        apply("R4", 3'd1, 2'd1, 64'h8000, 64'd16, 1'b1, 1'b0);
        apply("R5", 3'd2, 2'd0, 64'h82, 64'd2, 1'b1, 1'b0);
        apply("R5", 3'd2, 2'd0, 64'h80, 64'd25, 1'b1, 1'b0);
        apply("R5", 3'd2, 2'd3, 64'h8000_0000_0000_0000, 64'd63, 1'b1, 1'b0);
    endtask

    task automatic test_rotates();        // R6 R7
        apply("R6", 3'd3, 2'd0, 64'h81, 64'd1, 1'b1, 1'b0);
        apply("R6", 3'd3, 2'd0, 64'h5A, 64'd8, 1'b1, 1'b0);
        apply("R6", 3'd3, 2'd3, 64'h8000_0000_0000_0001, 64'd63, 1'b1, 1'b0);
        apply("R7", 3'd4, 2'd1, 64'h4001, 64'd1, 1'b1, 1'b0);
        apply("R7", 3'd4, 2'd0, 64'hC3, 64'd19, 1'b1, 1'b0);
    endtask

    task automatic test_through_carry();  // R8 R9
        apply("R8", 3'd5, 2'd0, 64'h80, 64'd1, 1'b1, 1'b0);
        apply("R8", 3'd5, 2'd0, 64'h5A, 64'd9, 1'b1, 1'b1);
        apply("R8", 3'd5, 2'd1, 64'h8001, 64'd17, 1'b1, 1'b1);
        apply("R9", 3'd6, 2'd0, 64'h01, 64'd1, 1'b1, 1'b1);
        apply("R9", 3'd6, 2'd2, 64'h8000_0001, 64'd33, 1'b0, 1'b0);
        apply("R9", 3'd6, 2'd3, 64'h1, 64'd63, 1'b1, 1'b1);
    endtask

    task automatic test_upper_bits();     // R10
        apply("R10", 3'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FF01, 64'd3, 1'b1, 1'b0);
        apply("R10", 3'd2, 2'd1, 64'hABCD_0000_0000_8000, 64'd4, 1'b1, 1'b0);
        apply("R10", 3'd4, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'd1, 1'b1, 1'b0);
    endtask

    task automatic test_ecf();            // R11
        for (int op = 0; op < 7; op++)
            apply("R11", 3'(op), 2'd3, 64'hC000_0000_0000_0003, 64'd2, 1'b1, 1'b1);
    endtask

    task automatic test_sweep();          // R3 to R9 mixed patterns
        for (int i = 0; i < 420; i++) begin
            lfsr = next_rand(lfsr);
            apply(op_tag(i % 7), 3'(i % 7), 2'((i / 7) % 4), lfsr, {57'd0, lfsr[63:57]},
                  lfsr[7], lfsr[11]);
        end
    endtask

    initial begin
        test_idle();
        test_zero_count();
        test_count_trunc();
        test_shifts();
        test_rotates();
        test_through_carry();
        test_upper_bits();
        test_ecf();
        test_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired after %0d vectors, expected completion", vectors);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule